// File: doc/BRIEF.md
# Dual-Channel ADC Output Formatter

This block sits between the two 12-bit sample paths of a dual-channel converter core and the chip's digital output pins. On every sample clock it takes one signed sample per channel, clamps it to the 12-bit range, and raises a range flag when clamping happened. It carries the sample and its flag through a fixed pipeline, then encodes the word as offset binary, two's complement or Gray code. Each channel's word goes out on its own bus, together with a data clock. The two channels can also share one bus, with channel A in the high clock phase and channel B in the low phase.

A small write-only register port sets the configuration. It holds the code format, interleaving, data-clock inversion, a per-channel port-off bit addressed through a channel mask, and a switch that lets an external active-high tri-state pin control the outputs. High impedance is modelled as per-bit output-enable vectors that travel beside the data.

Top module: `adcfmt_top`

## Requirements
- R1: While `rst_n` is low, both data buses read 0x000. Both range flags are low. Every output-enable bit is 1. The configuration returns to its defaults: offset binary, no interleave, no inversion, ports on, pin control off, channel mask 2'b11.
- R2: A sample present on `ch_x_i` at rising clock edge n is reflected on the data bus immediately after edge n+16, and not before.
- R3: In offset binary (format field 0), input -2048 gives 0x000, input 0 gives 0x800 and input +2047 gives 0xFFF. This format is the default after reset.
- R4: In two's complement (format field 1), input -2048 gives 0x800, input 0 gives 0x000 and input +2047 gives 0x7FF.
- R5: In Gray code (format field 2), the word is g = b ^ (b >> 1), where b is the offset-binary word of the sample.
- R6: An input above +2047 is clamped to the positive extreme code of the active format, and an input below -2048 to the negative extreme code. In both cases the range flag, which is aligned with its sample, is 1. For every input in [-2048, +2047], including -2048 itself, the flag is 0.
- R7: A mode write takes effect at the next clock edge. Every word leaving the pipeline after that edge uses the new mode, including samples that entered the pipeline before the write.
- R8: With interleave off, the data clock of each channel equals the sample clock, or its inverse when the inversion bit (mode bit 3) is set.
- R9: With interleave on (mode bit 2), bus A carries channel A's word and flag while the clock is high and channel B's while it is low. The channel A data clock is the inverted sample clock, further inverted by mode bit 3. Bus B keeps carrying channel B.
- R10: A mode write sets the port-off bit (mode bit 4) of every channel whose bit is set in the channel mask (address 0, bits [1:0]; bit 0 is A). Every other channel's port-off bit is unchanged. A channel whose port-off bit is set has all its data, flag and data-clock enables at 0.
- R11: After bit 0 of address 2 is set, `oeb_pin_i` high sets all enables of both channels to 0, and low leaves them as the port-off bits give. While that bit is clear, the pin has no effect.
- R12: A mode write with format field 3 selects offset binary. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_a_i | input | IN_W | Channel A sample, signed, mid-scale at 0 |
| ch_b_i | input | IN_W | Channel B sample, signed, mid-scale at 0 |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address: 0 channel mask, 1 mode, 2 pin control |
| cfg_wdata_i | input | 5 | Register write data |
| oeb_pin_i | input | 1 | External tri-state request, active high |
| dout_a_o | output | DATA_W | Bus A data word |
| dout_a_oe_o | output | DATA_W+1 | Bus A enables; MSB is for the range flag |
| or_a_o | output | 1 | Bus A range flag |
| dco_a_o | output | 1 | Channel A data clock |
| dco_a_oe_o | output | 1 | Channel A data-clock enable |
| dout_b_o | output | DATA_W | Bus B data word |
| dout_b_oe_o | output | DATA_W+1 | Bus B enables; MSB is for the range flag |
| or_b_o | output | 1 | Bus B range flag |
| dco_b_o | output | 1 | Channel B data clock |
| dco_b_oe_o | output | 1 | Channel B data-clock enable |

## Verification
The bench attacks the clamp edges -2049, -2048, +2047 and +2048 and the input-width extremes. A comparison that is off by one would flag -2048 as out of range, or would pass +2048 through with a wrapped sign. It switches format while the pipeline is full, so a design that tags samples with the mode in force on entry would show stale codes for sixteen cycles. In interleaved mode it samples the bus in both clock phases, which exposes swapped channels or a data clock of the wrong polarity. It also walks the channel mask and the pin-control switch, which would catch a port-off bit applied to the wrong channel or a pin that acts before it is enabled.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

   typedef enum logic [1:0] {
      FMT_OFFSET = 2'd0,
      FMT_TWOS   = 2'd1,
      FMT_GRAY   = 2'd2
   } fmt_e;

   localparam int CFG_AW = 2;
   localparam int CFG_DW = 5;

   localparam logic [CFG_AW-1:0] ADDR_CHMASK = 2'd0;
   localparam logic [CFG_AW-1:0] ADDR_MODE   = 2'd1;
   localparam logic [CFG_AW-1:0] ADDR_PINCTL = 2'd2;

   localparam int MODE_ILV_BIT = 2;
   localparam int MODE_INV_BIT = 3;
   localparam int MODE_OFF_BIT = 4;

   function automatic fmt_e decode_fmt(input logic [1:0] field);
      case (field)
         2'd1:    return FMT_TWOS;
         2'd2:    return FMT_GRAY;
         default: return FMT_OFFSET;
      endcase
   endfunction

endpackage

// File: rtl/adcfmt_sat.sv
module adcfmt_sat #(
   parameter int DATA_W = 12,
   parameter int IN_W   = 14
) (
   input  logic signed [IN_W-1:0] raw_i,
   output logic [DATA_W-1:0]      code_o,
   output logic                   oor_o
);
   localparam int HI_I = (1 << (DATA_W-1)) - 1;
   localparam int LO_I = -(1 << (DATA_W-1));
   localparam logic signed [IN_W-1:0] HI = HI_I[IN_W-1:0];
   localparam logic signed [IN_W-1:0] LO = LO_I[IN_W-1:0];
   localparam logic [DATA_W-1:0] POS_EXT = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_EXT = {1'b1, {(DATA_W-1){1'b0}}};

   if (IN_W <= DATA_W) begin : g_bad_width
      $error("adcfmt_sat: IN_W must exceed DATA_W");
   end

   always_comb begin
      if (raw_i > HI) begin
         code_o = POS_EXT;
         oor_o  = 1'b1;
      end else if (raw_i < LO) begin
         code_o = NEG_EXT;
         oor_o  = 1'b1;
      end else begin
         code_o = raw_i[DATA_W-1:0];
         oor_o  = 1'b0;
      end
   end
endmodule

// File: rtl/adcfmt_delay.sv
module adcfmt_delay #(
   parameter int W     = 13,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (DEPTH == 0) begin : g_wire
      assign q_o = d_i;
   end else begin : g_shift
      logic [W-1:0] stg [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
         end
      end

      assign q_o = stg[DEPTH-1];

      // R2: the head of the delay line captures the input on every edge
      a_r2_head_capture: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (stg[0] == $past(d_i)));
   end
endmodule

// File: rtl/adcfmt_cfg.sv
module adcfmt_cfg
   import adcfmt_pkg::*;
#(
   parameter int NCH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [CFG_AW-1:0] addr_i,
   input  logic [CFG_DW-1:0] wdata_i,
   output fmt_e              fmt_o,
   output logic              ilv_o,
   output logic              inv_o,
   output logic [NCH-1:0]    off_o,
   output logic              pin_en_o
);
   logic [NCH-1:0] chmask;

   if (NCH > CFG_DW) begin : g_bad_nch
      $error("adcfmt_cfg: channel mask wider than write data");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chmask   <= '1;
         fmt_o    <= FMT_OFFSET;
         ilv_o    <= 1'b0;
         inv_o    <= 1'b0;
         off_o    <= '0;
         pin_en_o <= 1'b0;
      end else if (we_i) begin
         case (addr_i)
            ADDR_CHMASK: chmask <= wdata_i[NCH-1:0];
            ADDR_MODE: begin
               fmt_o <= decode_fmt(wdata_i[1:0]);
               ilv_o <= wdata_i[MODE_ILV_BIT];
               inv_o <= wdata_i[MODE_INV_BIT];
               for (int c = 0; c < NCH; c++)
                  if (chmask[c]) off_o[c] <= wdata_i[MODE_OFF_BIT];
            end
            ADDR_PINCTL: pin_en_o <= wdata_i[0];
            default: ;
         endcase
      end
   end

   // R12: field value 3 falls back to offset binary
   a_r12_code3_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == ADDR_MODE && wdata_i[1:0] == 2'd3) |=> (fmt_o == FMT_OFFSET));

   for (genvar g = 0; g < NCH; g++) begin : g_chk
      // R10: port-off bit follows the mask, untouched otherwise
      a_r10_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
         (we_i && addr_i == ADDR_MODE) |=>
            (off_o[g] == ($past(chmask[g]) ? $past(wdata_i[MODE_OFF_BIT]) : $past(off_o[g]))));
   end
endmodule

// File: rtl/adcfmt_encode.sv
module adcfmt_encode
   import adcfmt_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] code_i,
   input  logic              oor_i,
   input  fmt_e              fmt_i,
   output logic [DATA_W-1:0] word_o,
   output logic              oor_o
);
   localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] ALL_ONE  = '1;
   localparam logic [DATA_W-1:0] ALL_ZERO = '0;
   localparam logic [DATA_W-1:0] LOW_ONES = {1'b0, {(DATA_W-1){1'b1}}};

   logic [DATA_W-1:0] offs;
   logic [DATA_W-1:0] enc;

   assign offs = code_i ^ MSB_ONLY;

   always_comb begin
      case (fmt_i)
         FMT_TWOS: enc = code_i;
         FMT_GRAY: enc = offs ^ (offs >> 1);
         default:  enc = offs;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= '0;
         oor_o  <= 1'b0;
      end else begin
         word_o <= enc;
         oor_o  <= oor_i;
      end
   end

   // R6: a flagged sample leaves as an extreme code of some format
   a_r6_flag_extreme: assert property (@(posedge clk) disable iff (!rst_n)
      oor_i |=> (oor_o && (word_o == ALL_ZERO || word_o == ALL_ONE ||
                           word_o == MSB_ONLY || word_o == LOW_ONES)));
endmodule

// File: rtl/adcfmt_top.sv
module adcfmt_top
   import adcfmt_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int IN_W    = 14,
   parameter int LATENCY = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic signed [IN_W-1:0] ch_a_i,
   input  logic signed [IN_W-1:0] ch_b_i,
   input  logic                   cfg_we_i,
   input  logic [CFG_AW-1:0]      cfg_addr_i,
   input  logic [CFG_DW-1:0]      cfg_wdata_i,
   input  logic                   oeb_pin_i,
   output logic [DATA_W-1:0]      dout_a_o,
   output logic [DATA_W:0]        dout_a_oe_o,
   output logic                   or_a_o,
   output logic                   dco_a_o,
   output logic                   dco_a_oe_o,
   output logic [DATA_W-1:0]      dout_b_o,
   output logic [DATA_W:0]        dout_b_oe_o,
   output logic                   or_b_o,
   output logic                   dco_b_o,
   output logic                   dco_b_oe_o
);
   localparam int NCH = 2;
   localparam int PW  = DATA_W + 1;

   if (LATENCY < 1) begin : g_bad_lat
      $error("adcfmt_top: LATENCY must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("adcfmt_top: DATA_W too small");
   end

   fmt_e           fmt;
   logic           ilv, inv, pin_en;
   logic [NCH-1:0] port_off;
   logic           ilv_q, inv_q;

   logic signed [IN_W-1:0] raw  [NCH];
   logic [DATA_W-1:0]      word [NCH];
   logic                   oor  [NCH];
   logic [NCH-1:0]         en;

   assign raw[0] = ch_a_i;
   assign raw[1] = ch_b_i;

   adcfmt_cfg #(.NCH(NCH)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
      .fmt_o(fmt), .ilv_o(ilv), .inv_o(inv), .off_o(port_off), .pin_en_o(pin_en)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic [DATA_W-1:0] sat_code;
      logic              sat_oor;
      logic [PW-1:0]     dly_q;

      adcfmt_sat #(.DATA_W(DATA_W), .IN_W(IN_W)) u_sat (
         .raw_i(raw[g]), .code_o(sat_code), .oor_o(sat_oor)
      );

      adcfmt_delay #(.W(PW), .DEPTH(LATENCY)) u_dly (
         .clk(clk), .rst_n(rst_n),
         .d_i({sat_oor, sat_code}), .q_o(dly_q)
      );

      adcfmt_encode #(.DATA_W(DATA_W)) u_enc (
         .clk(clk), .rst_n(rst_n),
         .code_i(dly_q[DATA_W-1:0]), .oor_i(dly_q[DATA_W]), .fmt_i(fmt),
         .word_o(word[g]), .oor_o(oor[g])
      );

      assign en[g] = ~(port_off[g] | (pin_en & oeb_pin_i));
   end

   // clock-side mode bits move with the output words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ilv_q <= 1'b0;
         inv_q <= 1'b0;
      end else begin
         ilv_q <= ilv;
         inv_q <= inv;
      end
   end

   logic show_b_on_a;
   assign show_b_on_a = ilv_q & ~clk;

   assign dout_a_o = show_b_on_a ? word[1] : word[0];
   assign or_a_o   = show_b_on_a ? oor[1]  : oor[0];
   assign dco_a_o  = (ilv_q ? ~clk : clk) ^ inv_q;
   assign dout_b_o = word[1];
   assign or_b_o   = oor[1];
   assign dco_b_o  = clk ^ inv_q;

   assign dout_a_oe_o = {PW{en[0]}};
   assign dco_a_oe_o  = en[0];
   assign dout_b_oe_o = {PW{en[1]}};
   assign dco_b_oe_o  = en[1];

   // R11: enabled pin control forces every driver off
   a_r11_pin_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_en && oeb_pin_i) |-> (dout_a_oe_o == '0 && dout_b_oe_o == '0 &&
                                 !dco_a_oe_o && !dco_b_oe_o));

   // R10: a port-off channel drives nothing
   a_r10_port_off: assert property (@(posedge clk) disable iff (!rst_n)
      port_off[0] |-> (dout_a_oe_o == '0 && !dco_a_oe_o));
endmodule

// File: tb/adcfmt_top_tb.sv
module adcfmt_top_tb;
   localparam int DW = 12;
   localparam int IW = 14;
   localparam int LAT = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic signed [IW-1:0] ch_a = '0, ch_b = '0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [4:0] cfg_wdata = '0;
   logic oeb = 1'b0;
   logic [DW-1:0] dout_a, dout_b;
   logic [DW:0] dout_a_oe, dout_b_oe;
   logic or_a, or_b, dco_a, dco_b, dco_a_oe, dco_b_oe;

   always #5 clk = ~clk;

   adcfmt_top u_dut (
      .clk(clk), .rst_n(rst_n), .ch_a_i(ch_a), .ch_b_i(ch_b),
      .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
      .oeb_pin_i(oeb),
      .dout_a_o(dout_a), .dout_a_oe_o(dout_a_oe), .or_a_o(or_a),
      .dco_a_o(dco_a), .dco_a_oe_o(dco_a_oe),
      .dout_b_o(dout_b), .dout_b_oe_o(dout_b_oe), .or_b_o(or_b),
      .dco_b_o(dco_b), .dco_b_oe_o(dco_b_oe)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   int m = 0;
   int hist_a [0:4095];
   int hist_b [0:4095];
   string tag = "R3";

   // model: c_* after the latest write, e_* as used by the output stage
   int c_fmt = 0, c_ilv = 0, c_inv = 0, c_pin = 0, c_sel = 3;
   int c_off [2] = '{0, 0};
   int e_fmt = 0, e_ilv = 0, e_inv = 0;

   function automatic logic [12:0] expw(input int v, input int f);
      int s; logic o; logic [11:0] tc, ob, w;
      if (v > 2047) begin s = 2047; o = 1'b1; end
      else if (v < -2048) begin s = -2048; o = 1'b1; end
      else begin s = v; o = 1'b0; end
      tc = s[11:0];
      ob = tc ^ 12'h800;
      case (f)
         1: w = tc;
         2: w = ob ^ (ob >> 1);
         default: w = ob;
      endcase
      return {o, w};
   endfunction

   function automatic int at(input int idx, input bit chb);
      if (idx < 0) return 0;
      return chb ? hist_b[idx] : hist_a[idx];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at edge %0d: actual 0x%0h expected 0x%0h", req, m, act, expv);
      end
   endtask

   task automatic check_en();
      logic ea, eb;
      ea = !(c_off[0] != 0 || (c_pin != 0 && oeb));
      eb = !(c_off[1] != 0 || (c_pin != 0 && oeb));
      chk(dout_a_oe == {13{ea}} && dco_a_oe == ea, {tag, " R10/R11 enable A"}, int'(dout_a_oe), int'({13{ea}}));
      chk(dout_b_oe == {13{eb}} && dco_b_oe == eb, {tag, " R10/R11 enable B"}, int'(dout_b_oe), int'({13{eb}}));
   endtask

   // clock high phase, 2 ns after the edge
   task automatic check_high();
      logic [12:0] xa, xb;
      xa = expw(at(m - LAT, 1'b0), e_fmt);
      xb = expw(at(m - LAT, 1'b1), e_fmt);
      chk({or_a, dout_a} == xa, {tag, " R2 bus A word/flag"}, int'({or_a, dout_a}), int'(xa));
      chk({or_b, dout_b} == xb, {tag, " R2 bus B word/flag"}, int'({or_b, dout_b}), int'(xb));
      if (e_ilv != 0)
         chk(dco_a == e_inv[0], {tag, " R9 dco A high phase"}, int'(dco_a), e_inv);
      else
         chk(dco_a == !e_inv[0], {tag, " R8 dco A high phase"}, int'(dco_a), int'(!e_inv[0]));
      chk(dco_b == !e_inv[0], {tag, " R8 dco B high phase"}, int'(dco_b), int'(!e_inv[0]));
      check_en();
   endtask

   // clock low phase, 2 ns after the falling edge
   task automatic check_low();
      logic [12:0] xa, xb;
      xa = expw(at(m - LAT, 1'b0), e_fmt);
      xb = expw(at(m - LAT, 1'b1), e_fmt);
      if (e_ilv != 0) begin
         chk({or_a, dout_a} == xb, {tag, " R9 bus A carries B"}, int'({or_a, dout_a}), int'(xb));
         chk(dco_a == !e_inv[0], {tag, " R9 dco A low phase"}, int'(dco_a), int'(!e_inv[0]));
      end else begin
         chk({or_a, dout_a} == xa, {tag, " R2 bus A low phase"}, int'({or_a, dout_a}), int'(xa));
         chk(dco_a == e_inv[0], {tag, " R8 dco A low phase"}, int'(dco_a), e_inv);
      end
      chk(dco_b == e_inv[0], {tag, " R8 dco B low phase"}, int'(dco_b), e_inv);
   endtask

   // called just after a falling edge; covers one full cycle
   task automatic step(input int va, input int vb, input bit we,
                       input logic [1:0] ad, input logic [4:0] wd, input bit pin);
      e_fmt = c_fmt; e_ilv = c_ilv; e_inv = c_inv;
      ch_a = va[IW-1:0];
      ch_b = vb[IW-1:0];
      hist_a[m+1] = va;
      hist_b[m+1] = vb;
      cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
      oeb = pin;
      if (we) begin
         case (ad)
            2'd0: c_sel = int'(wd[1:0]);
            2'd1: begin
               c_fmt = (wd[1:0] == 2'd3) ? 0 : int'(wd[1:0]);
               c_ilv = int'(wd[2]);
               c_inv = int'(wd[3]);
               for (int c = 0; c < 2; c++) if (c_sel[c]) c_off[c] = int'(wd[4]);
            end
            2'd2: c_pin = int'(wd[0]);
            default: ;
         endcase
      end
      @(posedge clk); m++; #2;
      check_high();
      @(negedge clk); #2;
      cfg_we = 1'b0;
      check_low();
   endtask

   function automatic int rnd();
      return int'($urandom_range(4700)) - 2350;
   endfunction

   task automatic run_rand(input int n, input bit pin);
      for (int i = 0; i < n; i++) step(rnd(), rnd(), 1'b0, 2'd0, 5'd0, pin);
   endtask

   task automatic run_corners();
      int cv [10] = '{-2048, -2049, 2047, 2048, 0, -1, 1, -8192, 8191, 2046};
      for (int i = 0; i < 10; i++) step(cv[i], cv[9-i], 1'b0, 2'd0, 5'd0, 1'b0);
      run_rand(LAT + 2, 1'b0);
   endtask

   task automatic wr(input logic [1:0] ad, input logic [4:0] wd, input bit pin);
      step(rnd(), rnd(), 1'b1, ad, wd, pin);
   endtask

   initial begin : watchdog
      #2000000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      int seed;
      seed = int'($urandom(32'd4242));
      for (int i = 0; i < 4096; i++) begin hist_a[i] = 0; hist_b[i] = 0; end
      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      chk(dout_a == '0 && dout_b == '0, "R1 reset data", int'(dout_a), 0);
      chk(!or_a && !or_b, "R1 reset flags", int'({or_a, or_b}), 0);
      chk(dout_a_oe == '1 && dout_b_oe == '1 && dco_a_oe && dco_b_oe, "R1 reset enables",
          int'(dout_a_oe), 13'h1fff);
      @(negedge clk); #2;
      rst_n = 1'b1;

      // R2/R3/R6: default offset binary; the first LAT edges hold the reset zeros
      tag = "R3"; run_rand(LAT + 8, 1'b0); run_corners();
      // R2: an isolated sample among zeros appears exactly LAT edges later
      tag = "R2";
      for (int i = 0; i < 4; i++) step(0, 0, 1'b0, 2'd0, 5'd0, 1'b0);
      step(1234, -777, 1'b0, 2'd0, 5'd0, 1'b0);
      for (int i = 0; i < LAT + 3; i++) step(0, 0, 1'b0, 2'd0, 5'd0, 1'b0);

      // R4, with R7 covering a full pipeline across the switch
      tag = "R7"; wr(2'd1, 5'b00001, 1'b0); run_rand(LAT, 1'b0);
      tag = "R4"; run_corners();
      tag = "R7"; wr(2'd1, 5'b00010, 1'b0); run_rand(LAT, 1'b0);
      tag = "R5"; run_corners();
      tag = "R12"; wr(2'd1, 5'b00011, 1'b0); run_corners();
      wr(2'd1, 5'b00001, 1'b0);
      wr(2'd3, 5'b11111, 1'b0); run_rand(8, 1'b0);

      // R8: inverted data clocks, non-interleaved
      tag = "R8"; wr(2'd1, 5'b01000, 1'b0); run_rand(12, 1'b0);
      // R9: interleaved, both polarities, with range corners
      tag = "R9"; wr(2'd1, 5'b00100, 1'b0); run_corners();
      wr(2'd1, 5'b01110, 1'b0); run_rand(LAT + 4, 1'b0);
      wr(2'd1, 5'b00000, 1'b0); run_rand(4, 1'b0);

      // R10: mask A only, turn it off; then B; then both back on
      tag = "R10";
      wr(2'd0, 5'b00001, 1'b0); wr(2'd1, 5'b10000, 1'b0); run_rand(4, 1'b0);
      wr(2'd0, 5'b00010, 1'b0); wr(2'd1, 5'b10001, 1'b0); run_rand(4, 1'b0);
      wr(2'd1, 5'b00000, 1'b0); run_rand(3, 1'b0);
      wr(2'd0, 5'b00011, 1'b0); wr(2'd1, 5'b00000, 1'b0); run_rand(LAT + 2, 1'b0);

      // R11: pin ignored until enabled, then gates both channels
      tag = "R11";
      run_rand(4, 1'b1);
      wr(2'd2, 5'b00001, 1'b1); run_rand(4, 1'b1);
      run_rand(4, 1'b0);
      run_rand(3, 1'b1);
      wr(2'd2, 5'b00000, 1'b1); run_rand(4, 1'b1);

      // mixed random traffic under every format
      tag = "R6";
      for (int f = 0; f < 3; f++) begin
         wr(2'd1, 5'(f), 1'b0);
         run_rand(LAT + 10, 1'b0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule